// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a single-lane SPI master that software drives through a 32-bit register window. The serial clock is derived from the system clock by a 12-bit divisor, and clock polarity and phase can each be selected. Bytes written to the transmit data register are queued in an 8-entry FIFO. A frame starts on its own whenever that queue holds data. In the normal direction each frame also captures the bits arriving on MISO into an 8-entry receive FIFO. Reading the receive data register pops one entry.

FIFO status comes back in bit 31 of the data registers themselves. A read of the transmit register reports "full", and a read of the receive register reports "empty", so a driver polls the same address it moves data through. Frame length (1 to 8 bits) and bit order are programmable.

One chip-select line is chosen by an index register, and every line has a programmable idle level. Hardware drives the chosen line in one of three ways. In per-frame mode it is asserted for each frame. In hold mode it stays asserted across frames until software touches the select configuration. In off mode the lines simply follow the idle-level register.

Top module: `spi_host`

## Requirements
- R1: After reset these registers read back as follows: divisor (0x00) = 3, clock mode (0x04) = 0, select index (0x10) = 0, idle levels (0x14) = all ones, select mode (0x18) = 0, format (0x40) = 0x0008_0000. Unimplemented offsets such as 0x28, 0x50, 0x60 and 0x70 read 0. SCK rests low and every cs_n line rests high.
- R2: Each SCK half period lasts div+1 clock cycles, where div is the value held at 0x00. Between frames SCK rests at the polarity bit, which is bit 1 of 0x04.
- R3: With format bit 2 clear, a frame of n bits sends data bits n-1 down to 0, most significant first. With bit 2 set it sends bits 0 up to n-1.
- R4: Bit 0 of 0x04 selects the phase. When it is 0, data is valid before the leading edge and is sampled on the leading edge. When it is 1, data changes on the leading edge and is sampled on the trailing edge. All four polarity/phase combinations move data correctly in both directions.
- R5: With format bit 3 clear, each frame pushes its received bits into the receive FIFO. Each bit is stored at the same position it would be sent from. A read of 0x4C pops one entry and returns it in bits [7:0] with bit 31 clear; when the FIFO is empty the read returns 0x8000_0000.
- R6: With format bit 3 set, frames still transmit but push nothing into the receive FIFO.
- R7: The transmit FIFO holds 8 bytes. Reading 0x48 returns bit 31 set only while it is full. A write to 0x48 while it is full is dropped, and an accepted write queues bits [7:0].
- R8: While the receive FIFO holds 8 entries and format bit 3 is clear, no frame starts. Transmission resumes once an entry is popped.
- R9: In select mode 0 (per frame), the line given by 0x10 is driven to the inverse of its idle bit for the whole frame and returns to its idle level afterwards. All other lines stay at their idle levels.
- R10: In select mode 2 (hold), the chosen line stays active after a frame ends. It is released when 0x10, 0x14 or 0x18 is written.
- R11: In select mode 3 (off), each cs_n line equals its idle bit in 0x14, including during frames. Writing a 0 to an idle bit drives that line low.
- R12: Format bits [19:16] give the frame length; the values 1 to 8 are used as written and 0 or values above 8 act as 8. The protocol field, bits [1:0], always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (pops the receive FIFO at 0x4C) |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | NCS | Chip-select lines |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: four chip-select lines, FIFOs 8 deep and a 12-bit divisor. The 8-entry depth means a burst of sixteen queued bytes reaches both the receive-full stall and the transmit-full drop within a few hundred cycles. Four select lines leave room to exercise a non-zero index and an active-high line. The divisor is programmed to 0, 1 and 2, so the half-period length is checked against more than one value. A slave model in the bench follows polarity, phase, order and length on its own and answers each frame with a known byte pattern.

// File: rtl/spi_host.sv
module spi_host #(
  parameter int NCS   = 4,
  parameter int DEPTH = 8,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             sck,
  output logic             mosi,
  output logic [NCS-1:0]   cs_n,
  input  logic             miso
);
  localparam int PW  = $clog2(DEPTH);
  localparam int IDW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam logic [PW:0] FULLV = (PW+1)'(DEPTH);

  localparam logic [7:0] A_DIV = 8'h00, A_MODE = 8'h04, A_ID = 8'h10, A_DEF = 8'h14;
  localparam logic [7:0] A_CSM = 8'h18, A_FMT = 8'h40, A_TX = 8'h48, A_RX = 8'h4C;
  localparam logic [1:0] HOLD = 2'd2, OFF = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;

  logic [DIV_W-1:0] div_q, cnt;
  logic             cpha_q, cpol_q, lsb_q, dir_q, hold_q, ph;
  logic [IDW-1:0]   csid_q;
  logic [NCS-1:0]   csdef_q;
  logic [1:0]       csmode_q;
  logic [3:0]       len_q, flen_q, eff_len;
  logic [4:0]       edg;
  logic [2:0]       bitn, pos;
  logic [7:0]       txsh, rxsh;
  st_t              st;

  logic [7:0]  tx_mem [DEPTH];
  logic [7:0]  rx_mem [DEPTH];
  logic [PW:0] tx_wp, tx_rp, rx_wp, rx_rp, tx_cnt, rx_cnt;

  wire we_div  = bus_we && bus_addr == A_DIV;
  wire we_mode = bus_we && bus_addr == A_MODE;
  wire we_id   = bus_we && bus_addr == A_ID;
  wire we_def  = bus_we && bus_addr == A_DEF;
  wire we_csm  = bus_we && bus_addr == A_CSM;
  wire we_fmt  = bus_we && bus_addr == A_FMT;
  wire tx_wr_req = bus_we && bus_addr == A_TX;

  wire unused_wdata = ^bus_wdata;

  assign tx_cnt = tx_wp - tx_rp;
  assign rx_cnt = rx_wp - rx_rp;
  wire tx_full  = tx_cnt == FULLV;
  wire rx_full  = rx_cnt == FULLV;
  wire rx_empty = rx_cnt == '0;

  wire busy  = st != S_IDLE;
  wire tick  = busy && cnt == div_q;
  wire last  = edg == ({flen_q, 1'b0} - 5'd1);
  wire start = !busy && tx_cnt != '0 && (dir_q || !rx_full);
  wire samp  = edg[0] == cpha_q;
  wire adv   = (edg[0] != cpha_q) && !(cpha_q ? (edg == 5'd0) : last);

  wire tx_push = tx_wr_req && !tx_full;
  wire tx_pop  = start;
  wire rx_push = st == S_GAP && tick && !dir_q && !rx_full;
  wire rx_pop  = bus_re && bus_addr == A_RX && !rx_empty;

  assign eff_len = (len_q == 4'd0 || len_q > 4'd8) ? 4'd8 : len_q;
  assign pos  = lsb_q ? bitn : 3'(flen_q - 4'd1 - {1'b0, bitn});
  assign mosi = txsh[pos];
  assign sck  = cpol_q ^ ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(3);
      cpha_q   <= 1'b0;
      cpol_q   <= 1'b0;
      csid_q   <= '0;
      csdef_q  <= '1;
      csmode_q <= '0;
      lsb_q    <= 1'b0;
      dir_q    <= 1'b0;
      len_q    <= 4'd8;
    end else begin
      if (we_div)  div_q <= bus_wdata[DIV_W-1:0];
      if (we_mode) {cpol_q, cpha_q} <= bus_wdata[1:0];
      if (we_id)   csid_q <= bus_wdata[IDW-1:0];
      if (we_def)  csdef_q <= bus_wdata[NCS-1:0];
      if (we_csm)  csmode_q <= bus_wdata[1:0];
      if (we_fmt) begin
        lsb_q <= bus_wdata[2];
        dir_q <= bus_wdata[3];
        len_q <= bus_wdata[19:16];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp[PW-1:0]] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp[PW-1:0]] <= rxsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0;
      tx_rp <= '0;
      rx_wp <= '0;
      rx_rp <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      edg    <= '0;
      bitn   <= '0;
      ph     <= 1'b0;
      txsh   <= '0;
      rxsh   <= '0;
      flen_q <= 4'd8;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            st     <= S_XFER;
            txsh   <= tx_mem[tx_rp[PW-1:0]];
            rxsh   <= '0;
            edg    <= '0;
            bitn   <= '0;
            ph     <= 1'b0;
            flen_q <= eff_len;
          end
        end
        S_XFER: begin
          if (tick) begin
            cnt <= '0;
            ph  <= ~ph;
            edg <= edg + 5'd1;
            if (samp) rxsh[pos] <= miso;
            if (adv)  bitn <= bitn + 3'd1;
            if (last) st <= S_GAP;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
        default: begin
          if (tick) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else begin
            cnt <= cnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hold_q <= 1'b0;
    else if (we_id || we_def || we_csm) hold_q <= 1'b0;
    else if (start && csmode_q == HOLD) hold_q <= 1'b1;
  end

  wire cs_act = csmode_q != OFF && (busy || (csmode_q == HOLD && hold_q));

  always_comb begin
    for (int i = 0; i < NCS; i++)
      cs_n[i] = csdef_q[i] ^ (cs_act && csid_q == IDW'(i));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      A_MODE: bus_rdata[1:0] = {cpol_q, cpha_q};
      A_ID:   bus_rdata[IDW-1:0] = csid_q;
      A_DEF:  bus_rdata[NCS-1:0] = csdef_q;
      A_CSM:  bus_rdata[1:0] = csmode_q;
      A_FMT: begin
        bus_rdata[2]     = lsb_q;
        bus_rdata[3]     = dir_q;
        bus_rdata[19:16] = len_q;
      end
      A_TX:   bus_rdata[31] = tx_full;
      A_RX: begin
        if (rx_empty) bus_rdata[31] = 1'b1;
        else          bus_rdata[7:0] = rx_mem[rx_rp[PW-1:0]];
      end
      default: ;
    endcase
  end
endmodule

module spi_host_chk #(
  parameter int NCS   = 4,
  parameter int DEPTH = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    sck,
  input logic                    cpol,
  input logic [NCS-1:0]          cs_n,
  input logic [NCS-1:0]          csdef,
  input logic [1:0]              csmode,
  input logic                    dir,
  input logic [$clog2(DEPTH):0]  tx_cnt,
  input logic [$clog2(DEPTH):0]  rx_cnt,
  input logic                    tx_wr,
  input logic                    tx_pop
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULLV = (PW+1)'(DEPTH);

  a_r2_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cpol);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULLV);

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_cnt == FULLV && !tx_pop) |=> tx_cnt == FULLV);

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == FULLV && !dir && !busy) |=> !busy);

  a_r8_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULLV);

  a_r9_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_n ^ csdef) <= 1);

  a_r11_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
    csmode == 2'd3 |-> cs_n == csdef);
endmodule

bind spi_host spi_host_chk #(.NCS(NCS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .cpol(cpol_q),
  .cs_n(cs_n), .csdef(csdef_q), .csmode(csmode_q), .dir(dir_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_wr(tx_wr_req), .tx_pop(tx_pop)
);

// File: tb/spi_host_tb.sv
module spi_host_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  wire         sck, mosi;
  wire [NCS-1:0] cs_n;
  logic        miso;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host #(.NCS(NCS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .miso(miso)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] d;

  bit slv_on = 0, b_cpol = 0, b_cpha = 0, b_lsb = 0;
  int b_len = 8, b_div = 3;
  int k = 0, nfr = 0, cyc = 0, lead_cyc = 0, hp_min = 999, hp_max = 0;
  logic [7:0] cur = '0;
  logic [7:0] cap [64];
  logic sck_prev = 1'b0;

  function automatic logic [7:0] rep(input int n);
    return 8'(8'h3C + n * 37);
  endfunction

  function automatic int spos(input int kk, input bit lsb, input int len);
    return lsb ? kk : len - 1 - kk;
  endfunction

  function automatic logic slv_bit(input int n, input int kk, input bit lsb, input int len);
    logic [7:0] r;
    r = rep(n);
    return r[spos(kk, lsb, len) & 7];
  endfunction

  function automatic logic [7:0] lmask(input int len);
    return 8'((1 << len) - 1);
  endfunction

  assign miso = slv_bit(nfr, k, b_lsb, b_len);

  always @(negedge clk) begin
    cyc++;
    if (slv_on && sck !== sck_prev) begin
      if (sck_prev == b_cpol) lead_cyc = cyc;
      else begin
        if (cyc - lead_cyc < hp_min) hp_min = cyc - lead_cyc;
        if (cyc - lead_cyc > hp_max) hp_max = cyc - lead_cyc;
      end
      if ((sck_prev == b_cpol) != b_cpha) begin
        cur[spos(k, b_lsb, b_len) & 7] = mosi;
        k++;
        if (k == b_len) begin
          cap[nfr % 64] = cur;
          nfr++;
          k = 0;
          cur = '0;
        end
      end
    end
    sck_prev = sck;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int g = 0;
    while (nfr < target && g < 20000) begin
      @(posedge clk);
      g++;
    end
    repeat (3 * (b_div + 1) + 4) @(posedge clk);
  endtask

  task automatic cfg(input bit pol, input bit pha, input int dv);
    slv_on = 0;
    wr(8'h00, 32'(dv));
    wr(8'h04, {30'd0, pol, pha});
    b_cpol = pol; b_cpha = pha; b_div = dv;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(8'h00); chk("R1 div", d, 32'd3);
    rd(8'h04); chk("R1 mode", d, 32'd0);
    rd(8'h10); chk("R1 csid", d, 32'd0);
    rd(8'h14); chk("R1 csdef", d, 32'hF);
    rd(8'h18); chk("R1 csmode", d, 32'd0);
    rd(8'h40); chk("R1 fmt", d, 32'h0008_0000);
    rd(8'h28); chk("R1 unused 28", d, 32'd0);
    rd(8'h50); chk("R1 unused 50", d, 32'd0);
    rd(8'h60); chk("R1 unused 60", d, 32'd0);
    rd(8'h70); chk("R1 unused 70", d, 32'd0);
    chk("R1 sck", {31'd0, sck}, 32'd0);
    chk("R1 cs_n", {28'd0, cs_n}, 32'hF);
  endtask

  task automatic t_basic;
    int base;
    cfg(0, 0, 1);
    slv_on = 1; hp_min = 999; hp_max = 0; base = nfr;
    wr(8'h48, 32'hA5);
    repeat (6) @(negedge clk);
    chk("R9 cs active", {28'd0, cs_n}, 32'hE);
    wait_frames(base + 1);
    chk("R9 cs released", {28'd0, cs_n}, 32'hF);
    chk("R3 msb first", {24'd0, cap[base % 64]}, 32'hA5);
    chk("R2 half min", hp_min, 2);
    chk("R2 half max", hp_max, 2);
    chk("R2 idle level", {31'd0, sck}, 32'd0);
    rd(8'h4C); chk("R5 rx data", d, {24'd0, rep(base)});
    rd(8'h4C); chk("R5 rx empty", d, 32'h8000_0000);
  endtask

  task automatic t_modes;
    for (int m = 0; m < 4; m++) begin
      int base;
      logic [7:0] tb;
      cfg(m[1], m[0], 2);
      chk("R2 idle polarity", {31'd0, sck}, {31'd0, m[1]});
      slv_on = 1; hp_min = 999; hp_max = 0; base = nfr;
      tb = 8'(8'h96 + m * 8'h29);
      wr(8'h48, {24'd0, tb});
      wait_frames(base + 1);
      chk("R4 mosi", {24'd0, cap[base % 64]}, {24'd0, tb});
      rd(8'h4C); chk("R4 miso", d, {24'd0, rep(base)});
      chk("R2 half period", hp_max, 3);
      chk("R2 half period min", hp_min, 3);
    end
  endtask

  task automatic t_fmt;
    int base;
    cfg(0, 0, 0);
    wr(8'h40, 32'h0000_0004); b_lsb = 1;
    slv_on = 1; base = nfr;
    wr(8'h48, 32'h0D);
    wait_frames(base + 1);
    chk("R3 lsb first", {24'd0, cap[base % 64]}, 32'h0D);
    rd(8'h4C); chk("R3 lsb rx", d, {24'd0, rep(base)});
    wr(8'h40, 32'h0005_0000); b_lsb = 0; b_len = 5; base = nfr;
    wr(8'h48, 32'hF6);
    wait_frames(base + 1);
    chk("R12 len 5 tx", {24'd0, cap[base % 64]}, 32'h16);
    rd(8'h4C); chk("R12 len 5 rx", d, {24'd0, rep(base) & lmask(5)});
    wr(8'h40, 32'h0000_0003); b_len = 8;
    rd(8'h40); chk("R12 proto reads 0", d, 32'd0);
    base = nfr;
    wr(8'h48, 32'hC3);
    wait_frames(base + 1);
    chk("R12 len 0 acts as 8", {24'd0, cap[base % 64]}, 32'hC3);
    rd(8'h4C); chk("R12 len 0 rx", d, {24'd0, rep(base)});
    wr(8'h40, 32'h0008_0000);
  endtask

  task automatic t_dir;
    int base;
    base = nfr;
    wr(8'h40, 32'h0008_0008);
    wr(8'h48, 32'h11);
    wr(8'h48, 32'h22);
    wait_frames(base + 2);
    chk("R6 tx first", {24'd0, cap[base % 64]}, 32'h11);
    chk("R6 tx second", {24'd0, cap[(base + 1) % 64]}, 32'h22);
    rd(8'h4C); chk("R6 no rx push", d, 32'h8000_0000);
    wr(8'h40, 32'h0008_0000);
  endtask

  task automatic t_full;
    int base;
    base = nfr;
    for (int i = 0; i < 8; i++) wr(8'h48, 32'h40 + 32'(i));
    wait_frames(base + 8);
    rd(8'h48); chk("R7 not full", d, 32'd0);
    for (int i = 0; i < 8; i++) wr(8'h48, 32'h50 + 32'(i));
    rd(8'h48); chk("R7 full flag", d, 32'h8000_0000);
    wr(8'h48, 32'hEE);
    repeat (80) @(negedge clk);
    chk("R8 stalled", nfr, base + 8);
    chk("R8 cs idle", {28'd0, cs_n}, 32'hF);
    for (int i = 0; i < 8; i++) begin
      rd(8'h4C); chk("R5 rx order", d, {24'd0, rep(base + i)});
    end
    wait_frames(base + 16);
    repeat (100) @(negedge clk);
    chk("R7 drop count", nfr, base + 16);
    chk("R7 last byte", {24'd0, cap[(base + 15) % 64]}, 32'h57);
    for (int i = 0; i < 8; i++) begin
      rd(8'h4C); chk("R8 resumed rx", d, {24'd0, rep(base + 8 + i)});
    end
    rd(8'h4C); chk("R5 drained", d, 32'h8000_0000);
  endtask

  task automatic t_hold;
    int base;
    wr(8'h18, 32'd2);
    wr(8'h10, 32'd1);
    base = nfr;
    wr(8'h48, 32'h5A);
    wr(8'h48, 32'h3C);
    wait_frames(base + 2);
    chk("R10 held", {28'd0, cs_n}, 32'hD);
    wr(8'h10, 32'd1);
    chk("R10 release on id", {28'd0, cs_n}, 32'hF);
    wr(8'h48, 32'h01);
    wait_frames(base + 3);
    chk("R10 held again", {28'd0, cs_n}, 32'hD);
    wr(8'h14, 32'hF);
    chk("R10 release on default", {28'd0, cs_n}, 32'hF);
    wr(8'h48, 32'h02);
    wait_frames(base + 4);
    chk("R10 held third", {28'd0, cs_n}, 32'hD);
    wr(8'h18, 32'd2);
    chk("R10 release on mode", {28'd0, cs_n}, 32'hF);
    for (int i = 0; i < 4; i++) rd(8'h4C);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'd0);
  endtask

  task automatic t_off;
    int base;
    wr(8'h18, 32'd3);
    wr(8'h14, 32'hB);
    chk("R11 forced low", {28'd0, cs_n}, 32'hB);
    base = nfr;
    wr(8'h48, 32'h77);
    repeat (8) @(negedge clk);
    chk("R11 no hw drive", {28'd0, cs_n}, 32'hB);
    wait_frames(base + 1);
    rd(8'h4C);
    wr(8'h18, 32'd0);
    wr(8'h10, 32'd3);
    wr(8'h14, 32'h7);
    chk("R9 idle low line", {28'd0, cs_n}, 32'h7);
    wr(8'h48, 32'h99);
    repeat (8) @(negedge clk);
    chk("R9 inverse of default", {28'd0, cs_n}, 32'hF);
    wait_frames(base + 2);
    chk("R9 back to default", {28'd0, cs_n}, 32'h7);
    rd(8'h4C);
    wr(8'h14, 32'hF);
    wr(8'h10, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_fmt();
    t_dir();
    t_full();
    t_hold();
    t_off();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule